// File: doc/BRIEF.md
# Prescaled PWM Timer

This block is a memory-mapped timer that drives several edge-aligned PWM outputs from a single shared up-counter. Software programs a prescaler and a modulus. It gives each channel a compare value and an output configuration, and then starts the counter through a two-bit run field. The counter advances once per prescaled tick and returns to zero after it reaches the modulus, so one period is modulus plus one ticks. Each channel compares the live count with its value to form its output, with a polarity that software selects.

The counter is driven by a two-state machine. In `ST_HALT` the count holds, and every modulus and channel value written is copied straight into its active register. The `START` transition goes to `ST_RUN` when the run field holds 01. In `ST_RUN` the count advances on every prescaler tick, and new modulus and compare values are taken only at the wrap, so a period is never cut short or stretched mid-way. The `STOP` transition returns to `ST_HALT` as soon as the run field holds any other value. The state register follows the control register one cycle later.

Registers are reached over a simple single-cycle bus: address, write enable, write data, and combinational read data.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is halted at 0 and all PWM outputs are low.
- R2: While running, the count advances exactly once every 2^P input clock cycles, where P is control bits [2:0] (codes 0 to 7 divide by 1 to 128).
- R3: Control bits [4:3] = 01 run the counter; any other value halts it and the count holds its value.
- R4: The count steps by one from 0 up to the modulus (0x18), then returns to 0 on the next tick; a count at or above the modulus wraps.
- R5: With channel mode bits [5:4] = 10 and edge bits [3:2] = 10 or 11, the channel output is high while count < value and low otherwise.
- R6: With mode 10 and edge bits 01, the channel output is low while count < value and high otherwise.
- R7: Edge bits 00, or any mode other than 10, hold the channel output low.
- R8: A value of 0 keeps the output inactive for the whole period; a value above the modulus keeps it active for the whole period.
- R9: While running, newly written modulus and channel values take effect only at the wrap; while halted they take effect in the next cycle.
- R10: Any write to the counter register (0x14) clears the count to 0 in the next cycle, whatever the data.
- R11: Reads return control bits [5:0] at 0x10 (bit 5 is stored only, counting is always upward), the live count at 0x14, the written modulus at 0x18, channel n configuration in bits [5:2] at 0x20+8n and its written value at 0x24+8n; every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Register byte address |
| we | input | 1 | Write strobe, one write per asserted cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The hardest case to reach is a modulus or compare write that lands in the middle of a running period. That write must stay invisible until the wrap, and in the halted state the same write looks the same as one that took effect at once. The bench polls the live count through the bus, so it can place both writes at a known count. It picks an old modulus of 9 and a new one of 5, so the counter reaching 6 proves that the old modulus is still in force. It also picks compare values so that the old and new ones give opposite output levels at that count.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

    localparam int ADDR_CTRL    = 'h10;
    localparam int ADDR_CNT     = 'h14;
    localparam int ADDR_MOD     = 'h18;
    localparam int ADDR_CH_BASE = 'h20;
    localparam int CH_STRIDE    = 'h08;
    localparam int CH_VAL_OFS   = 'h04;

    localparam logic [1:0] RUN_CODE  = 2'b01;
    localparam logic [1:0] EDGE_MODE = 2'b10;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pdiv_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((32'd1 << sel) - 32'd1);
        tick = run && ((pdiv_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdiv_q <= '0;
        end else if (!run || clr) begin
            pdiv_q <= '0;
        end else begin
            pdiv_q <= pdiv_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          clr,
    input  logic          tick,
    input  logic          mod_we,
    input  logic [CW-1:0] mod_wdata,
    output logic          running,
    output logic          reload,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] mod_buf,
    output logic [CW-1:0] mod_act
);
    cnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, mod_buf_q, mod_act_q;
    logic          wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (mode == RUN_CODE) state_d = ST_RUN;
            ST_RUN:  if (mode != RUN_CODE) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN);
        wrap    = running && tick && (cnt_q >= mod_act_q);
        reload  = !running || wrap;
        cnt     = cnt_q;
        mod_buf = mod_buf_q;
        mod_act = mod_act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            mod_buf_q <= '0;
            mod_act_q <= '0;
        end else begin
            if (clr)                  cnt_q <= '0;
            else if (running && tick) cnt_q <= wrap ? '0 : cnt_q + CW'(1);
            if (mod_we) mod_buf_q <= mod_wdata;
            if (reload) mod_act_q <= mod_buf_q;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_wdata,
    input  logic          val_we,
    input  logic [CW-1:0] val_wdata,
    input  logic          reload,
    input  logic [CW-1:0] cnt,
    output logic [3:0]    cfg,
    output logic [CW-1:0] val_buf,
    output logic [CW-1:0] val_act,
    output logic          pwm
);
    logic [3:0]    cfg_q;
    logic [CW-1:0] val_buf_q, val_act_q;
    logic          below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            val_buf_q <= '0;
            val_act_q <= '0;
        end else begin
            if (cfg_we) cfg_q     <= cfg_wdata;
            if (val_we) val_buf_q <= val_wdata;
            if (reload) val_act_q <= val_buf_q;
        end
    end

    always_comb begin
        cfg     = cfg_q;
        val_buf = val_buf_q;
        val_act = val_act_q;
        below   = (cnt < val_act_q);
        if (cfg_q[3:2] != EDGE_MODE || cfg_q[1:0] == 2'b00) pwm = 1'b0;
        else if (cfg_q[1])                                  pwm = below;
        else                                                pwm = !below;
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int CW     = 16,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CTRL_W   = PS_W + 3;
    localparam int MODE_LSB = PS_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              cnt_clr, mod_we, running, reload, tick;
    logic [CW-1:0]     cnt, mod_buf, mod_act;
    logic [3:0]        ch_cfg     [NUM_CH];
    logic [CW-1:0]     ch_val_buf [NUM_CH];
    logic [CW-1:0]     ch_val_act [NUM_CH];
    logic              unused_wdata;

    assign unused_wdata = ^wdata;
    assign cnt_clr      = we && (addr == AW'(ADDR_CNT));
    assign mod_we       = we && (addr == AW'(ADDR_MOD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (we && addr == AW'(ADDR_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
    end

    pwm_prescaler #(.PS_W(PS_W)) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .clr  (cnt_clr),
        .sel  (ctrl_q[PS_W-1:0]),
        .tick (tick)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctrl_q[MODE_LSB +: 2]),
        .clr      (cnt_clr),
        .tick     (tick),
        .mod_we   (mod_we),
        .mod_wdata(wdata[CW-1:0]),
        .running  (running),
        .reload   (reload),
        .cnt      (cnt),
        .mod_buf  (mod_buf),
        .mod_act  (mod_act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int CFG_A = ADDR_CH_BASE + g * CH_STRIDE;
        localparam int VAL_A = CFG_A + CH_VAL_OFS;
        pwm_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (we && addr == AW'(CFG_A)),
            .cfg_wdata(wdata[5:2]),
            .val_we   (we && addr == AW'(VAL_A)),
            .val_wdata(wdata[CW-1:0]),
            .reload   (reload),
            .cnt      (cnt),
            .cfg      (ch_cfg[g]),
            .val_buf  (ch_val_buf[g]),
            .val_act  (ch_val_act[g]),
            .pwm      (pwm_out[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_CTRL)) rdata = DW'(ctrl_q);
        if (addr == AW'(ADDR_CNT))  rdata = DW'(cnt);
        if (addr == AW'(ADDR_MOD))  rdata = DW'(mod_buf);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == AW'(ADDR_CH_BASE + i * CH_STRIDE))
                rdata = DW'({ch_cfg[i], 2'b00});
            if (addr == AW'(ADDR_CH_BASE + i * CH_STRIDE + CH_VAL_OFS))
                rdata = DW'(ch_val_buf[i]);
        end
    end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  addr,
    input logic [31:0] rdata,
    input logic        running,
    input logic        tick,
    input logic        cnt_clr,
    input logic        reload,
    input logic [2:0]  ps_sel,
    input logic [15:0] cnt,
    input logic [15:0] mod_act,
    input logic [3:0]  cfg0,
    input logic [15:0] val_act0,
    input logic        pwm0
);
    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == 16'd0));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_clr) |=> $stable(cnt));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cnt_clr && cnt >= mod_act) |=> (cnt == 16'd0));

    // R9
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !reload) |=> ($stable(val_act0) && $stable(mod_act)));

    // R7
    chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0[3:2] != 2'b10 || cfg0[1:0] == 2'b00) |-> !pwm0);

    // R2
    div1_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ps_sel == 3'd0) |-> tick);

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h08 || addr == 8'h1C) |-> (rdata == 32'd0));
endmodule

bind pwm_timer pwm_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rdata   (rdata),
    .running (running),
    .tick    (tick),
    .cnt_clr (cnt_clr),
    .reload  (reload),
    .ps_sel  (ctrl_q[2:0]),
    .cnt     (cnt),
    .mod_act (mod_act),
    .cfg0    (ch_cfg[0]),
    .val_act0(ch_val_act[0]),
    .pwm0    (pwm_out[0])
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
    localparam int A_CTRL = 'h10, A_CNT = 'h14, A_MOD = 'h18;
    localparam int A_C0 = 'h20, A_V0 = 'h24, A_C1 = 'h28, A_V1 = 'h2C;

    typedef struct packed {
        logic [2:0]  ps;
        logic [1:0]  els;
        logic [15:0] modv;
        logic [15:0] val;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 2'b10, 16'd9, 16'd4},
        '{3'd1, 2'b10, 16'd5, 16'd0},
        '{3'd2, 2'b10, 16'd3, 16'd7},
        '{3'd0, 2'b01, 16'd7, 16'd3},
        '{3'd3, 2'b00, 16'd2, 16'd1},
        '{3'd0, 2'b10, 16'd0, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    function automatic logic exp_out(input logic [15:0] c, input logic [15:0] v,
                                     input logic [1:0] ms, input logic [1:0] els);
        if (ms != 2'b10 || els == 2'b00) return 1'b0;
        return els[1] ? (c < v) : !(c < v);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        addr = 8'(a); wdata = 32'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        addr = 8'(a);
        #1 d = rdata;
    endtask

    task automatic wait_cnt(input int v, output logic found);
        logic [31:0] d;
        found = 1'b0;
        for (int k = 0; k < 64 && !found; k++) begin
            @(negedge clk);
            bus_read(A_CNT, d);
            if (d == 32'(v)) found = 1'b1;
        end
    endtask

    task automatic run_vector(input vec_t v);
        logic [31:0] d;
        logic [15:0] prev;
        int len, changes, e_seq, e_int, e_o0, e_o1, n;
        logic seen;
        string tag;
        bus_write(A_CTRL, 0);
        bus_write(A_CNT, 0);
        bus_write(A_MOD, int'(v.modv));
        bus_write(A_C0, int'({2'b10, v.els, 2'b00}));
        bus_write(A_V0, int'(v.val));
        bus_write(A_C1, 'h28);
        bus_write(A_V1, 2);
        bus_write(A_CTRL, int'({3'b001, v.ps}));
        n = (int'(v.modv) + 2) * (1 << v.ps) * 2 + 10;
        seen = 1'b0; len = 0; changes = 0;
        e_seq = 0; e_int = 0; e_o0 = 0; e_o1 = 0;
        @(negedge clk);
        bus_read(A_CNT, d);
        prev = d[15:0];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_read(A_CNT, d);
            if (d[15:0] != prev) begin
                changes++;
                if (d[15:0] != ((prev >= v.modv) ? 16'd0 : prev + 16'd1)) e_seq++;
                if (seen && len != (1 << v.ps)) e_int++;
                seen = 1'b1;
                len = 1;
            end else begin
                len++;
            end
            prev = d[15:0];
            if (pwm_out[0] != exp_out(d[15:0], v.val, 2'b10, v.els)) e_o0++;
            if (pwm_out[1] != exp_out(d[15:0], 16'd2, 2'b10, 2'b10)) e_o1++;
        end
        check(e_seq == 0 && (v.modv == 0 || changes >= int'(v.modv) + 1),
              "R4 count sequence", e_seq, 0);
        check(e_int == 0, "R2 prescale interval", e_int, 0);
        if (v.els == 2'b00)                          tag = "R7 channel output";
        else if (v.els == 2'b01)                     tag = "R6 channel output";
        else if (v.val == 0 || v.val > v.modv)       tag = "R8 channel output";
        else                                         tag = "R5 channel output";
        check(e_o0 == 0, tag, e_o0, 0);
        check(e_o1 == 0, "R5 second channel output", e_o1, 0);
    endtask

    task automatic sample_chk(input logic [1:0] ms, input logic [1:0] els, input string req);
        logic [31:0] d;
        int errs = 0;
        bus_write(A_CTRL, 0);
        bus_write(A_MOD, 9);
        bus_write(A_C0, int'({ms, els, 2'b00}));
        bus_write(A_V0, 4);
        bus_write(A_CTRL, 'h08);
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            bus_read(A_CNT, d);
            if (pwm_out[0] != exp_out(d[15:0], 16'd4, ms, els)) errs++;
        end
        check(errs == 0, req, errs, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d, c1, c2;
        logic found;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_CTRL, d); check(d == 0, "R1 control reset", int'(d), 0);
        bus_read(A_CNT, d);  check(d == 0, "R1 counter reset", int'(d), 0);
        bus_read(A_MOD, d);  check(d == 0, "R1 modulus reset", int'(d), 0);
        check(pwm_out == 2'b00, "R1 outputs low", int'(pwm_out), 0);

        // R11 readback and unmapped addresses
        bus_write(A_MOD, 'h1234);
        bus_read(A_MOD, d);  check(d == 32'h1234, "R11 modulus readback", int'(d), 'h1234);
        bus_write(A_C1, 'hFF);
        bus_read(A_C1, d);   check(d == 32'h3C, "R11 channel config readback", int'(d), 'h3C);
        bus_write(A_CTRL, 'hE7);
        bus_read(A_CTRL, d); check(d == 32'h27, "R11 control readback", int'(d), 'h27);
        bus_read('h08, d);   check(d == 0, "R11 unmapped 0x08", int'(d), 0);
        bus_read('h1C, d);   check(d == 0, "R11 unmapped 0x1C", int'(d), 0);
        bus_read('h30, d);   check(d == 0, "R11 unmapped 0x30", int'(d), 0);

        // Vector table: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < 6; i++) run_vector(VECS[i]);

        // R10 counter write clears
        bus_write(A_CTRL, 0);
        bus_write(A_MOD, 100);
        bus_write(A_CTRL, 'h08);
        repeat (20) @(negedge clk);
        bus_write(A_CNT, 'h55);
        bus_read(A_CNT, d);  check(d == 0, "R10 counter cleared", int'(d), 0);

        // R3 halt holds the count
        repeat (10) @(negedge clk);
        bus_write(A_CTRL, 'h10);
        repeat (2) @(negedge clk);
        bus_read(A_CNT, c1);
        repeat (5) @(negedge clk);
        bus_read(A_CNT, c2);
        check(c1 == c2 && c1 != 0, "R3 halted count holds", int'(c2), int'(c1));

        // R9 buffered update while running
        bus_write(A_CTRL, 0);
        bus_write(A_CNT, 0);
        bus_write(A_MOD, 9);
        bus_write(A_C0, 'h28);
        bus_write(A_V0, 4);
        bus_write(A_CTRL, 'h08);
        wait_cnt(1, found);
        bus_write(A_V0, 8);
        bus_write(A_MOD, 5);
        wait_cnt(6, found);
        check(found, "R9 old modulus kept until wrap", int'(found), 1);
        check(pwm_out[0] == 1'b0, "R9 old value kept until wrap", int'(pwm_out[0]), 0);
        wait_cnt(0, found);
        errs = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            bus_read(A_CNT, d);
            if (d > 5 || pwm_out[0] != 1'b1) errs++;
        end
        check(errs == 0, "R9 new values after wrap", errs, 0);

        // R7 non-edge mode, R5 edge bits 11
        sample_chk(2'b01, 2'b10, "R7 mode not edge-aligned");
        sample_chk(2'b10, 2'b11, "R5 edge bits 11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule